// File: doc/BRIEF.md
# CAN Controller Initialization and Error-Counter Control

This block holds the state a CAN controller needs while it is reset and configured by software. It keeps a control register with an initialization bit, a general-purpose auxiliary register, and the receive and transmit error counters. A small host port writes these registers and reads them back. While the initialization bit is set, the protocol engine is kept offline and the transmit pin is held recessive. A gate output also allows host writes into configuration memory, so that traffic in flight cannot be disturbed.

A system reset leaves the block in initialization mode with both counters cleared. Software may preset both error counters to one common value with a single write, but only while initialization mode is active. Clearing the initialization bit enables the protocol engine on the following clock edge. From then on, the counters move only through saturating increment and decrement strobes from the engine.

Top module: `can_init_ctrl`

## Requirements
- R1: After a synchronous reset, the control register reads 09h (bit 0 is the initialization bit), the auxiliary register reads 00h, both counters are 0, `engine_en` is 0 and `can_tx` is 1.
- R2: While control bit 0 is 1, `can_tx` is 1 and `engine_en` is 0, whatever `engine_tx_bit` is.
- R3: A host write that sets control bit 0 leaves both error counters unchanged.
- R4: While control bit 0 is 1, a write to address 1 loads the written byte into both the transmit and the receive counter, and both are visible from the next cycle.
- R5: While control bit 0 is 0, writes to address 1 and to address 2 have no effect on either counter.
- R6: `cfg_wr_grant` equals `cfg_wr_req` while control bit 0 is 1, and is 0 otherwise.
- R7: When a write clears control bit 0, `engine_en` rises on the next clock edge. From that point `can_tx` follows `engine_tx_bit`.
- R8: Outside initialization, an increment strobe alone raises a counter by 1 and stops at 255. A decrement strobe alone lowers it by 1 and stops at 0. Both strobes together leave the counter unchanged.
- R9: While control bit 0 is 1, increment and decrement strobes are ignored.
- R10: Reads return control at address 0, the transmit counter at 1, the receive counter at 2 and the auxiliary register at 3. Control and auxiliary store every bit written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| cfg_wr_req | input | 1 | Host wants to write configuration memory |
| cfg_wr_grant | output | 1 | Configuration write allowed |
| engine_tx_bit | input | 1 | Bit stream from the protocol engine |
| can_tx | output | 1 | Transmit pin, 1 is recessive |
| engine_en | output | 1 | Protocol engine enable |
| tec_inc | input | 1 | Transmit counter increment strobe |
| tec_dec | input | 1 | Transmit counter decrement strobe |
| rec_inc | input | 1 | Receive counter increment strobe |
| rec_dec | input | 1 | Receive counter decrement strobe |
| tec_cnt | output | 8 | Transmit error counter |
| rec_cnt | output | 8 | Receive error counter |

## Verification
The bench builds the block with its defaults: 8-bit counters and a control reset value of 09h. With those values, both saturation limits are reached by presetting a counter near its limit through the initialization load. This avoids hundreds of strobes. The narrow 2-bit address space lets the bench sweep every read and write target, including writes to the read-only receive address.

// File: rtl/can_init_pkg.sv
package can_init_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int INIT_BIT = 0;
    localparam logic [DATA_W-1:0] CTRL_RST_VAL = 8'h09;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_TEC  = 2'd1,
        REG_REC  = 2'd2,
        REG_AUX  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        reg_addr_e         addr;
        logic [DATA_W-1:0] data;
    } host_req_t;

    typedef struct packed {
        logic inc;
        logic dec;
    } cnt_step_t;

    typedef struct packed {
        logic              load;
        logic [DATA_W-1:0] value;
    } cnt_load_t;

endpackage

// File: rtl/can_err_counter.sv
module can_err_counter
    import can_init_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  cnt_step_t    step,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_MIN = '0;

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (!hold) begin
            if (step.inc && !step.dec && cnt_q != CNT_MAX) begin
                cnt_d = cnt_q + 1'b1;
            end else if (step.dec && !step.inc && cnt_q != CNT_MIN) begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    a_r1_cnt_reset: assert property (@(posedge clk) rst |=> cnt == '0);
    a_r4_load_taken: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));
    a_r9_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (hold && !load) |=> $stable(cnt));
    a_r8_top_sat: assert property (@(posedge clk) disable iff (rst)
        (!hold && !load && cnt == CNT_MAX && step.inc) |=> cnt == CNT_MAX);
    a_r8_floor_sat: assert property (@(posedge clk) disable iff (rst)
        (!hold && !load && cnt == CNT_MIN && step.dec) |=> cnt == CNT_MIN);

endmodule

// File: rtl/can_init_regs.sv
module can_init_regs
    import can_init_pkg::*;
#(
    parameter logic [DATA_W-1:0] CTRL_RST = CTRL_RST_VAL
) (
    input  logic              clk,
    input  logic              rst,
    input  host_req_t         req,
    input  logic [DATA_W-1:0] tec_val,
    input  logic [DATA_W-1:0] rec_val,
    output logic              init_mode,
    output cnt_load_t         preset,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] aux_q;
    logic              ctrl_we;
    logic              aux_we;

    assign ctrl_we = req.wr && req.addr == REG_CTRL;
    assign aux_we  = req.wr && req.addr == REG_AUX;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            aux_q  <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= req.data;
            if (aux_we)  aux_q  <= req.data;
        end
    end

    assign init_mode    = ctrl_q[INIT_BIT];
    assign preset.load  = req.wr && req.addr == REG_TEC && init_mode;
    assign preset.value = req.data;

    always_comb begin
        unique case (req.addr)
            REG_CTRL: rdata = ctrl_q;
            REG_TEC:  rdata = tec_val;
            REG_REC:  rdata = rec_val;
            REG_AUX:  rdata = aux_q;
            default:  rdata = '0;
        endcase
    end

    a_r1_ctrl_reset: assert property (@(posedge clk) rst |=> init_mode && rdata == (req.addr == REG_CTRL ? CTRL_RST : rdata));
    a_r10_ctrl_store: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> ctrl_q == $past(req.data));
    a_r5_no_preset_live: assert property (@(posedge clk) disable iff (rst)
        !init_mode |-> !preset.load);

endmodule

// File: rtl/can_tx_gate.sv
module can_tx_gate (
    input  logic clk,
    input  logic rst,
    input  logic init_mode,
    input  logic engine_tx_bit,
    input  logic cfg_wr_req,
    output logic engine_en,
    output logic can_tx,
    output logic cfg_wr_grant
);
    logic run_q;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= !init_mode;
    end

    assign engine_en    = run_q && !init_mode;
    assign can_tx       = engine_en ? engine_tx_bit : 1'b1;
    assign cfg_wr_grant = cfg_wr_req && init_mode;

    a_r2_recessive: assert property (@(posedge clk) disable iff (rst)
        init_mode |-> (can_tx && !engine_en));
    a_r7_enable_next: assert property (@(posedge clk) disable iff (rst)
        $fell(init_mode) |-> !engine_en ##1 (engine_en || init_mode));
    a_r6_gate_only_init: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_grant |-> init_mode);
    a_r1_offline_reset: assert property (@(posedge clk) rst |=> !engine_en && can_tx);

endmodule

// File: rtl/can_init_ctrl.sv
module can_init_ctrl
    import can_init_pkg::*;
#(
    parameter logic [DATA_W-1:0] CTRL_RST = CTRL_RST_VAL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              cfg_wr_req,
    output logic              cfg_wr_grant,
    input  logic              engine_tx_bit,
    output logic              can_tx,
    output logic              engine_en,
    input  logic              tec_inc,
    input  logic              tec_dec,
    input  logic              rec_inc,
    input  logic              rec_dec,
    output logic [DATA_W-1:0] tec_cnt,
    output logic [DATA_W-1:0] rec_cnt
);
    host_req_t  req;
    cnt_load_t  preset;
    logic       init_mode;
    cnt_step_t  steps [2];
    logic [DATA_W-1:0] cnts [2];

    assign req.wr   = host_wr;
    assign req.addr = reg_addr_e'(host_addr);
    assign req.data = host_wdata;

    assign steps[0] = '{inc: tec_inc, dec: tec_dec};
    assign steps[1] = '{inc: rec_inc, dec: rec_dec};

    can_init_regs #(.CTRL_RST(CTRL_RST)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .tec_val   (cnts[0]),
        .rec_val   (cnts[1]),
        .init_mode (init_mode),
        .preset    (preset),
        .rdata     (host_rdata)
    );

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        can_err_counter #(.W(DATA_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .hold     (init_mode),
            .load     (preset.load),
            .load_val (preset.value),
            .step     (steps[g]),
            .cnt      (cnts[g])
        );
    end

    assign tec_cnt = cnts[0];
    assign rec_cnt = cnts[1];

    can_tx_gate u_gate (
        .clk           (clk),
        .rst           (rst),
        .init_mode     (init_mode),
        .engine_tx_bit (engine_tx_bit),
        .cfg_wr_req    (cfg_wr_req),
        .engine_en     (engine_en),
        .can_tx        (can_tx),
        .cfg_wr_grant  (cfg_wr_grant)
    );

    a_r3_enter_keeps: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'd0 && host_wdata[0] && init_mode)
        |=> (tec_cnt == $past(tec_cnt) && rec_cnt == $past(rec_cnt)));
    a_r4_same_value: assert property (@(posedge clk) disable iff (rst)
        $past(preset.load) |-> tec_cnt == rec_cnt);

endmodule

// File: tb/can_init_ctrl_bench.sv
module can_init_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       cfg_wr_req = 1'b0;
    logic       cfg_wr_grant;
    logic       engine_tx_bit = 1'b1;
    logic       can_tx;
    logic       engine_en;
    logic       tec_inc = 1'b0, tec_dec = 1'b0, rec_inc = 1'b0, rec_dec = 1'b0;
    logic [7:0] tec_cnt, rec_cnt;

    int    n_checks = 0;
    int    n_bad    = 0;
    int    cycles   = 0;
    string cur_req  = "R1";

    // behavioural reference state
    int m_ctrl = 9, m_aux = 0, m_tec = 0, m_rec = 0;
    bit m_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_init_ctrl u_can_init_ctrl (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cfg_wr_req(cfg_wr_req), .cfg_wr_grant(cfg_wr_grant),
        .engine_tx_bit(engine_tx_bit), .can_tx(can_tx), .engine_en(engine_en),
        .tec_inc(tec_inc), .tec_dec(tec_dec), .rec_inc(rec_inc), .rec_dec(rec_dec),
        .tec_cnt(tec_cnt), .rec_cnt(rec_cnt)
    );

    function automatic int step_cnt(int c, bit inc, bit dec);
        if (inc && !dec && c < 255) return c + 1;
        if (dec && !inc && c > 0)   return c - 1;
        return c;
    endfunction

    always @(posedge clk) begin
        bit init_now;
        init_now = m_ctrl[0];
        if (rst) begin
            m_ctrl = 9; m_aux = 0; m_tec = 0; m_rec = 0; m_run = 0;
        end else begin
            m_run = !init_now;
            if (!init_now) begin
                m_tec = step_cnt(m_tec, tec_inc, tec_dec);
                m_rec = step_cnt(m_rec, rec_inc, rec_dec);
            end
            if (host_wr) begin
                case (host_addr)
                    2'd0: m_ctrl = host_wdata;
                    2'd1: if (init_now) begin m_tec = host_wdata; m_rec = host_wdata; end
                    2'd3: m_aux = host_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always begin
        int e_en, e_rd;
        @(negedge clk);
        #(CLK_PERIOD/4);
        cycles++;
        if (!rst) begin
            e_en = (m_run && !m_ctrl[0]) ? 1 : 0;
            case (host_addr)
                2'd0: e_rd = m_ctrl;
                2'd1: e_rd = m_tec;
                2'd2: e_rd = m_rec;
                default: e_rd = m_aux;
            endcase
            chk(cur_req, "engine_en", engine_en, e_en);
            chk(cur_req, "can_tx", can_tx, e_en ? engine_tx_bit : 1);
            chk(cur_req, "cfg_wr_grant", cfg_wr_grant, cfg_wr_req && m_ctrl[0]);
            chk(cur_req, "tec_cnt", tec_cnt, m_tec);
            chk(cur_req, "rec_cnt", rec_cnt, m_rec);
            chk(cur_req, "host_rdata", host_rdata, e_rd);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [1:0] a, int exp);
        @(negedge clk);
        host_addr = a;
        #(CLK_PERIOD/2);
        chk(req, "read", host_rdata, exp);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        cur_req = "R1";
        rd_chk("R1", 2'd0, 8'h09);
        rd_chk("R1", 2'd3, 8'h00);
        chk("R1", "tec", tec_cnt, 0);
        chk("R1", "rec", rec_cnt, 0);
        chk("R1", "can_tx", can_tx, 1);
        // R2 / R9 / R6 in init mode
        cur_req = "R2";
        engine_tx_bit = 1'b0;
        tec_inc = 1; rec_inc = 1; idle(3);
        cur_req = "R9";
        tec_inc = 0; rec_inc = 0; tec_dec = 1; idle(2); tec_dec = 0;
        chk("R9", "tec frozen", tec_cnt, 0);
        chk("R2", "can_tx recessive", can_tx, 1);
        cur_req = "R6";
        cfg_wr_req = 1; idle(2);
        chk("R6", "grant", cfg_wr_grant, 1);
        // R4 preset both
        cur_req = "R4";
        wr(2'd1, 8'h7e);
        chk("R4", "tec", tec_cnt, 8'h7e);
        chk("R4", "rec", rec_cnt, 8'h7e);
        // R7 leave init
        cur_req = "R7";
        engine_tx_bit = 1'b0;
        @(negedge clk); host_wr = 1; host_addr = 2'd0; host_wdata = 8'h08;
        @(negedge clk); host_wr = 0;
        chk("R7", "en one cycle later", engine_en, 0);
        chk("R6", "grant dropped", cfg_wr_grant, 0);
        @(negedge clk);
        chk("R7", "en", engine_en, 1);
        chk("R7", "tx follows 0", can_tx, 0);
        engine_tx_bit = 1'b1; idle(1);
        chk("R7", "tx follows 1", can_tx, 1);
        cfg_wr_req = 0;
        // R8 stepping
        cur_req = "R8";
        tec_inc = 1; rec_dec = 1; idle(4);
        tec_inc = 0; rec_dec = 0;
        chk("R8", "tec up", tec_cnt, 8'h82);
        chk("R8", "rec down", rec_cnt, 8'h7a);
        tec_inc = 1; tec_dec = 1; idle(3); tec_inc = 0; tec_dec = 0;
        chk("R8", "both no change", tec_cnt, 8'h82);
        // R5 writes ignored while running
        cur_req = "R5";
        wr(2'd1, 8'h11);
        wr(2'd2, 8'h22);
        chk("R5", "tec", tec_cnt, 8'h82);
        chk("R5", "rec", rec_cnt, 8'h7a);
        // R10 register map
        cur_req = "R10";
        wr(2'd3, 8'hc5);
        rd_chk("R10", 2'd3, 8'hc5);
        rd_chk("R10", 2'd1, 8'h82);
        rd_chk("R10", 2'd2, 8'h7a);
        rd_chk("R10", 2'd0, 8'h08);
        // R3 re-enter init keeps counters
        cur_req = "R3";
        wr(2'd0, 8'hf1);
        chk("R3", "tec kept", tec_cnt, 8'h82);
        chk("R3", "rec kept", rec_cnt, 8'h7a);
        rd_chk("R10", 2'd0, 8'hf1);
        chk("R2", "en off", engine_en, 0);
        // R8 saturation at top
        cur_req = "R8";
        wr(2'd1, 8'hfb);
        wr(2'd0, 8'h00);
        tec_inc = 1; rec_inc = 1; idle(10); tec_inc = 0; rec_inc = 0;
        chk("R8", "tec top", tec_cnt, 255);
        chk("R8", "rec top", rec_cnt, 255);
        // R8 saturation at floor
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h00);
        tec_dec = 1; rec_dec = 1; idle(6); tec_dec = 0; rec_dec = 0;
        chk("R8", "tec floor", tec_cnt, 0);
        chk("R8", "rec floor", rec_cnt, 0);
        // R1 reset again from running state
        cur_req = "R1";
        tec_inc = 1; idle(2); tec_inc = 0;
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        chk("R1", "tec", tec_cnt, 0);
        chk("R1", "en", engine_en, 0);
        rd_chk("R1", 2'd0, 8'h09);
        idle(2);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > WATCHDOG);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule